// File: doc/BRIEF.md
# Cycle-Period FSK Bit Decoder

This block turns a squared-up frequency-shift-keyed line signal back into bits. An external comparator slices the received sine wave into a 0/1 level. Each full cycle of that level carries one bit, and the two bit values use two different frequencies. The comparator threshold sits close to a waveform peak, so the high and low phases are far from equal. The decoder therefore ignores duty cycle and times only the interval from one rising edge to the next.

The asynchronous input first passes through a two-flop synchroniser and then a three-sample majority vote, which removes single-sample spikes and dropouts. A cycle counter runs between filtered rising edges. The measured period is compared with two windows, each ±25% around a nominal value that is a whole number of 5 µs steps. A period inside the long window yields a 0 and a period inside the short window yields a 1. Any other period raises an error strobe. When the line stays quiet for too long, the decoder drops back to idle, and the next rising edge only restarts timing.

Top module: `fsk_period_decoder`

## Requirements
- R1: While `rst_n` is low and on the first clock after it rises, `bit_valid`, `bit_val` and `bit_err` are all 0.
- R2: A `line_in` high lasting a single clock sample during a low phase, or a low lasting a single sample during a high phase, creates no rising edge and does not alter the decoded bit stream.
- R3: With P the number of clock cycles between two successive filtered rising edges, and Z = ZERO_TICKS*CLKS_PER_TICK, a P in [Z - Z/4, Z + Z/4] gives a one-cycle pulse on `bit_valid` with `bit_val` = 0.
- R4: With O = ONE_TICKS*CLKS_PER_TICK, a P in [O - O/4, O + O/4] gives a one-cycle pulse on `bit_valid` with `bit_val` = 1.
- R5: A P outside both windows, and not longer than the timeout T = 2*max(Z, O), gives a one-cycle pulse on `bit_err` and no `bit_valid`. `bit_valid` and `bit_err` are never high together.
- R6: If no rising edge comes within T cycles of the previous one (P > T), the decoder returns to idle, and that late edge produces neither a bit nor an error.
- R7: The first rising edge after reset or after an idle return only starts timing and produces no output.
- R8: A result pulse appears on the fifth rising clock edge, counting the first edge that samples `line_in` high at the start of the next cycle.
- R9: The decoded value depends only on the rising-to-rising period. High times anywhere from a few cycles to most of the period give the same result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Asynchronous square wave from the slicer |
| bit_valid | output | 1 | One-cycle strobe: a bit was decoded |
| bit_val | output | 1 | Decoded bit value, meaningful with `bit_valid` |
| bit_err | output | 1 | One-cycle strobe: period fits neither window |

## Verification
The bench sends runs of nominal long and short cycles with very different high times. These runs show that only the rising-to-rising period decides the bit. Periods exactly on each window edge, and one cycle beyond it, separate the inclusive bounds from the error region, including the gap between the two windows. Periods of exactly the timeout and one cycle longer separate an error report from a silent return to idle. Lines with one-sample spikes and dropouts show that the majority filter adds no edges and removes none.

// File: rtl/fsk_period_decoder.sv
module fsk_period_decoder #(
  parameter int CLKS_PER_TICK = 1000,
  parameter int ZERO_TICKS    = 20,
  parameter int ONE_TICKS     = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic bit_valid,
  output logic bit_val,
  output logic bit_err
);

  localparam int ZERO_C  = ZERO_TICKS * CLKS_PER_TICK;
  localparam int ONE_C   = ONE_TICKS * CLKS_PER_TICK;
  localparam int LONG_C  = (ZERO_C > ONE_C) ? ZERO_C : ONE_C;
  localparam int TOUT_C  = 2 * LONG_C;
  localparam int CW      = $clog2(TOUT_C + 2);
  localparam logic [CW-1:0] Z_LO = CW'(ZERO_C - ZERO_C / 4);
  localparam logic [CW-1:0] Z_HI = CW'(ZERO_C + ZERO_C / 4);
  localparam logic [CW-1:0] O_LO = CW'(ONE_C - ONE_C / 4);
  localparam logic [CW-1:0] O_HI = CW'(ONE_C + ONE_C / 4);
  localparam logic [CW-1:0] TOUT = CW'(TOUT_C);

  logic [1:0]    sync_q;
  logic [2:0]    hist_q;
  logic          filt_q;
  logic          meas_q;
  logic [CW-1:0] cnt_q;

  wire maj     = (hist_q[0] & hist_q[1]) | (hist_q[0] & hist_q[2]) | (hist_q[1] & hist_q[2]);
  wire rise    = maj & ~filt_q;
  wire in_zero = (cnt_q >= Z_LO) && (cnt_q <= Z_HI);
  wire in_one  = (cnt_q >= O_LO) && (cnt_q <= O_HI);
  wire judge   = rise & meas_q;
  wire expired = meas_q & ~rise & (cnt_q == TOUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      hist_q    <= '0;
      filt_q    <= 1'b0;
      meas_q    <= 1'b0;
      cnt_q     <= '0;
      bit_valid <= 1'b0;
      bit_val   <= 1'b0;
      bit_err   <= 1'b0;
    end else begin
      sync_q    <= {sync_q[0], line_in};
      hist_q    <= {hist_q[1:0], sync_q[1]};
      filt_q    <= maj;
      bit_valid <= judge & (in_zero | in_one);
      bit_val   <= judge & in_one;
      bit_err   <= judge & ~(in_zero | in_one);
      if (rise) begin
        meas_q <= 1'b1;
        cnt_q  <= CW'(1);
      end else if (expired) begin
        meas_q <= 1'b0;
      end else if (meas_q) begin
        cnt_q  <= cnt_q + CW'(1);
      end
    end
  end

  p_excl_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_valid && bit_err));

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |=> !bit_err);

  p_idle_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !meas_q) |=> (!bit_valid && !bit_err));

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOUT);

  p_zero_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bit_val) |-> ($past(cnt_q) >= Z_LO && $past(cnt_q) <= Z_HI));

  p_one_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_val) |-> ($past(cnt_q) >= O_LO && $past(cnt_q) <= O_HI));

endmodule

// File: tb/fsk_period_decoder_tb.sv
module fsk_period_decoder_tb_top;

  localparam int CPT = 4;
  localparam int ZT  = 20;
  localparam int OT  = 10;
  localparam int ZN  = ZT * CPT;
  localparam int ON  = OT * CPT;
  localparam int TO  = 2 * ((ZN > ON) ? ZN : ON);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic bit_valid, bit_val, bit_err;

  always #2.5 clk = ~clk;

  fsk_period_decoder #(.CLKS_PER_TICK(CPT), .ZERO_TICKS(ZT), .ONE_TICKS(OT)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_in(din),
    .bit_valid(bit_valid), .bit_val(bit_val), .bit_err(bit_err));

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  // behavioural reference
  bit q[$] = '{0, 0, 0, 0, 0, 0};
  bit m_meas = 0;
  int m_cnt = 0;
  bit e_valid = 0, e_val = 0, e_err = 0;
  int n_zero = 0, n_one = 0, n_err = 0;

  function automatic bit maj3(bit a, bit b, bit c);
    return (a + b + c) >= 2;
  endfunction

  // 0: bit0, 1: bit1, 2: error, 3: silent restart
  function automatic int kind(int p);
    if (p >= ZN - ZN / 4 && p <= ZN + ZN / 4) return 0;
    if (p >= ON - ON / 4 && p <= ON + ON / 4) return 1;
    if (p <= TO) return 2;
    return 3;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q = '{0, 0, 0, 0, 0, 0};
      m_meas = 0; m_cnt = 0;
      e_valid = 0; e_val = 0; e_err = 0;
    end else begin
      bit mc, mp;
      mc = maj3(q[2], q[3], q[4]);
      mp = maj3(q[3], q[4], q[5]);
      e_valid = 0; e_val = 0; e_err = 0;
      if (mc && !mp) begin
        if (m_meas) begin
          case (kind(m_cnt))
            0: e_valid = 1;
            1: begin e_valid = 1; e_val = 1; end
            default: e_err = 1;
          endcase
        end
        m_meas = 1; m_cnt = 1;
      end else if (m_meas) begin
        if (m_cnt == TO) m_meas = 0;
        else m_cnt++;
      end
      q.push_front(din);
      void'(q.pop_back());
    end
  end

  task automatic check(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  // cycle-by-cycle compare (R8 timing covered here)
  always @(negedge clk) begin
    if (rst_n) begin
      check({tag, " R8 valid"}, bit_valid, e_valid);
      check({tag, " bit_val"}, bit_val, e_val);
      check({tag, " R5 err"}, bit_err, e_err);
      if (bit_valid && !bit_val) n_zero++;
      if (bit_valid && bit_val) n_one++;
      if (bit_err) n_err++;
    end
  end

  task automatic drive(bit v, int n);
    din = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic cyc(int p, int h);
    drive(1, h);
    drive(0, p - h);
  endtask

  task automatic closing();
    drive(1, 10);
    drive(0, TO + 40);
  endtask

  task automatic clear_counts();
    n_zero = 0; n_one = 0; n_err = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", bit_valid, 0);
    check("R1 reset err", bit_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset valid", bit_valid, 0);
    check("R1 post-reset bit", bit_val, 0);

    tag = "R3";
    clear_counts();
    cyc(ZN, ZN / 2); cyc(ZN - ZN / 4, 8); cyc(ZN + ZN / 4, ZN);
    closing();
    check("R3 zero count", n_zero, 3);
    check("R3 no errors", n_err, 0);

    tag = "R4";
    clear_counts();
    cyc(ON, ON / 2); cyc(ON - ON / 4, 3); cyc(ON + ON / 4, ON);
    closing();
    check("R4 one count", n_one, 3);
    check("R4 no zeros", n_zero, 0);

    tag = "R5";
    clear_counts();
    cyc(ZN - ZN / 4 - 1, 5); cyc(ZN + ZN / 4 + 1, 50);
    cyc(ON - ON / 4 - 1, 4); cyc(ON + ON / 4 + 1, 40); cyc(TO, 20);
    closing();
    check("R5 err count", n_err, 5);
    check("R5 no bits", n_zero + n_one, 0);

    tag = "R9";
    clear_counts();
    cyc(ZN, 3); cyc(ZN, ZN - 3); cyc(ON, 2); cyc(ON, ON - 2);
    closing();
    check("R9 zeros any duty", n_zero, 2);
    check("R9 ones any duty", n_one, 2);

    tag = "R2";
    clear_counts();
    for (int i = 0; i < 3; i++) begin
      drive(1, 10); drive(0, 1); drive(1, 10);
      drive(0, 20); drive(1, 1); drive(0, ZN - 42);
    end
    closing();
    check("R2 glitched zeros", n_zero, 3);
    check("R2 no spurious err", n_err, 0);

    tag = "R6";
    clear_counts();
    cyc(TO + 1, 20); cyc(ZN, 30);
    closing();
    check("R6 late edge silent err", n_err, 0);
    check("R6 after restart", n_zero, 1);

    tag = "R7";
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    clear_counts();
    cyc(ON, 10);
    check("R7 first edge silent", n_zero + n_one + n_err, 0);
    closing();
    check("R7 one bit after first edge", n_one, 1);

    summary();
  end

endmodule